// File: doc/BRIEF.md
# Byte-Enable Emulating Write Bridge

The bridge joins a 32-bit bus master that drives per-byte lane enables to a 32-bit slave port that has no lane enables and always stores whole words. If such a slave were handed a narrow write directly, it would store zeros in every lane that the master did not mean to touch. The bridge prevents this by splitting every write with a partial lane mask into two slave accesses. The first is a read of the word at the aligned address, which is the byte address with its two lowest bits cleared. The second writes back that word with only the enabled lanes replaced by the master's data.

Reads and writes that enable all four lanes go straight through without delay. A write that enables no lane finishes at once and never reaches the slave. During the two-access sequence the master is held off through its wait signal, and the bridge takes no new request until the sequence has finished. Both sides follow a wait-request handshake with zero read latency: a slave access completes in the cycle in which the strobe is high and the slave's wait signal is low, and read data is valid in that same cycle.

Top module: `rmw_byte_bridge`

## Requirements
- R1: A write with mask 4'b1111 becomes one slave write in the same cycle, with the master's address aligned, the data unchanged and no slave read. The master's wait signal follows the slave's wait signal.
- R2: A master read becomes a slave read at the aligned address in the same cycle. The slave's read data and wait signal are returned to the master unchanged.
- R3: A write with a partial mask (not 0 and not 4'b1111) first issues one slave read. Its address is the master address with bits [1:0] cleared, so byte address 9203 is read as word 9200.
- R4: After that read, the bridge issues one slave write to the same aligned address. For each lane i whose mask bit i is 1, the written data bits [8i+7:8i] come from the master. Every other lane keeps the value that was read.
- R5: For a partial write, the master's wait signal stays high from the first cycle of the request until the write-back has been accepted. It then goes low for exactly one cycle, so a slave that never stalls holds the master off for 3 cycles.
- R6: A write with mask 4'b0000 completes in its first cycle with the wait signal low, and causes no slave read or slave write.
- R7: A stalled slave stretches each access. A strobe is held with a stable address while the slave's wait signal is high, so with w stall cycles per access a partial write holds the master off for 3+2w cycles.
- R8: The slave never sees a read and a write strobe together. While a sequence is running, its captured address stays fixed and master inputs are ignored. Each master transfer causes at most one read and one write on the slave.
- R9: While the active-low synchronous reset is low, both slave strobes are low and the master's wait signal is high. After reset the bridge is idle, and its wait signal is low when no request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_addr | input | ADDR_W | Master byte address |
| mst_read | input | 1 | Master read strobe |
| mst_write | input | 1 | Master write strobe |
| mst_lanes | input | LANES | Master byte-lane enable mask |
| mst_wdata | input | DATA_W | Master write data |
| mst_rdata | output | DATA_W | Read data returned to the master |
| mst_wait | output | 1 | Wait request to the master |
| slv_addr | output | ADDR_W | Word-aligned byte address to the slave |
| slv_read | output | 1 | Slave read strobe |
| slv_write | output | 1 | Slave write strobe |
| slv_wdata | output | DATA_W | Full-word write data to the slave |
| slv_rdata | input | DATA_W | Slave read data |
| slv_wait | input | 1 | Slave wait request |

## Verification
The hardest case to reach is a partial write on a slave that stalls. Here the read phase and the write-back phase must each hold their strobe and address through several cycles, and the merge must still use the data from the one accepted read. The bench slave model has a per-vector stall count of 0 to 3 cycles per access. The vector table mixes stall counts with full, partial, empty and unaligned lane masks, all aimed at words whose contents are already known. After each write, the bench compares the stored word with its own lane merge, the number of slave reads and writes, the aligned read address and the exact number of held-off cycles. It then reads the word back through the master port.

// File: rtl/rmw_bridge_pkg.sv
`timescale 1ns/1ps
// Shared types of the byte-enable emulating bridge.
// Assumes: state and mask-class encodings are used only inside the bridge.
package rmw_bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } rmw_state_e;

    typedef enum logic [1:0] {
        MASK_NONE = 2'd0,
        MASK_PART = 2'd1,
        MASK_FULL = 2'd2
    } mask_kind_e;

endpackage

// File: rtl/rmw_mask_classify.sv
`timescale 1ns/1ps
// Classifies a lane-enable mask as empty, partial or full.
// Assumes: LANES >= 1; purely combinational.
module rmw_mask_classify
    import rmw_bridge_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] lanes,
    output mask_kind_e       kind
);

    // Reduce the mask to one of three classes.
    always_comb begin
        if (&lanes)      kind = MASK_FULL;
        else if (|lanes) kind = MASK_PART;
        else             kind = MASK_NONE;
    end

endmodule

// File: rtl/rmw_byte_merge.sv
`timescale 1ns/1ps
// Per-lane merge: enabled lanes take the new data, other lanes keep the old word.
// Assumes: DATA_W is a multiple of 8; purely combinational.
module rmw_byte_merge #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [LANES-1:0]  lanes,
    output logic [DATA_W-1:0] merged
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Select the source of one byte lane.
        assign merged[8*g +: 8] = lanes[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
    end

endmodule

// File: rtl/rmw_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer for partial writes: captures the request, then reads the aligned
// word, captures the merged word and writes it back before completing.
// Assumes: master holds its request while waited; slave read data is valid
// in the cycle its read is accepted.
module rmw_seq_fsm
    import rmw_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr_al,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              slv_wait,
    input  logic [DATA_W-1:0] merged_in,
    output rmw_state_e        state,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [LANES-1:0]  hold_lanes,
    output logic [DATA_W-1:0] hold_wdata,
    output logic [DATA_W-1:0] merged_q
);

    rmw_state_e state_q;

    // Advance the sequence and capture request and merged data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hold_addr  <= '0;
            hold_lanes <= '0;
            hold_wdata <= '0;
            merged_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q    <= ST_READ;
                    hold_addr  <= req_addr_al;
                    hold_lanes <= req_lanes;
                    hold_wdata <= req_wdata;
                end
                ST_READ: if (!slv_wait) begin
                    state_q  <= ST_WRITE;
                    merged_q <= merged_in;
                end
                ST_WRITE: if (!slv_wait) state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign state = state_q;

    // R8: captured address is frozen while a sequence runs
    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(hold_addr));

    // R4: the write phase is only ever entered from an accepted read
    assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && $past(state_q) != ST_WRITE) |-> ($past(state_q) == ST_READ && !$past(slv_wait)));

endmodule

// File: rtl/rmw_byte_bridge.sv
`timescale 1ns/1ps
// Bridge that emulates byte-lane enables on a whole-word slave. Reads and
// full-mask writes pass through combinationally; partial writes become an
// aligned read followed by a merged write-back; empty-mask writes finish
// without a slave access.
// Assumes: zero-latency slave reads; master holds request while waited;
// a simultaneous read and write request is treated as a read.
module rmw_byte_bridge
    import rmw_bridge_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     mst_addr,
    input  logic                  mst_read,
    input  logic                  mst_write,
    input  logic [DATA_W/8-1:0]   mst_lanes,
    input  logic [DATA_W-1:0]     mst_wdata,
    output logic [DATA_W-1:0]     mst_rdata,
    output logic                  mst_wait,
    output logic [ADDR_W-1:0]     slv_addr,
    output logic                  slv_read,
    output logic                  slv_write,
    output logic [DATA_W-1:0]     slv_wdata,
    input  logic [DATA_W-1:0]     slv_rdata,
    input  logic                  slv_wait
);

    localparam int LANES = DATA_W / 8;
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LANES - 1);

    logic [ADDR_W-1:0] addr_al;
    mask_kind_e        kind;
    rmw_state_e        state;
    logic [ADDR_W-1:0] hold_addr;
    logic [LANES-1:0]  hold_lanes;
    logic [DATA_W-1:0] hold_wdata;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] merged_q;
    logic              start;

    assign addr_al = mst_addr & ~OFF_MASK;
    assign start   = mst_write && !mst_read && (kind == MASK_PART);

    rmw_mask_classify #(.LANES(LANES)) i_classify (
        .lanes (mst_lanes),
        .kind  (kind)
    );

    rmw_byte_merge #(.DATA_W(DATA_W), .LANES(LANES)) i_merge (
        .old_word (slv_rdata),
        .new_word (hold_wdata),
        .lanes    (hold_lanes),
        .merged   (merged)
    );

    rmw_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_addr_al (addr_al),
        .req_lanes   (mst_lanes),
        .req_wdata   (mst_wdata),
        .slv_wait    (slv_wait),
        .merged_in   (merged),
        .state       (state),
        .hold_addr   (hold_addr),
        .hold_lanes  (hold_lanes),
        .hold_wdata  (hold_wdata),
        .merged_q    (merged_q)
    );

    // Drive slave strobes and master wait from the sequence state.
    always_comb begin
        slv_read  = 1'b0;
        slv_write = 1'b0;
        slv_addr  = addr_al;
        slv_wdata = mst_wdata;
        mst_rdata = slv_rdata;
        mst_wait  = 1'b0;
        if (!rst_n) begin
            mst_wait = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mst_read) begin
                        slv_read = 1'b1;
                        mst_wait = slv_wait;
                    end else if (mst_write) begin
                        unique case (kind)
                            MASK_FULL: begin
                                slv_write = 1'b1;
                                mst_wait  = slv_wait;
                            end
                            MASK_PART: mst_wait = 1'b1;
                            default:   mst_wait = 1'b0;
                        endcase
                    end
                end
                ST_READ: begin
                    slv_read = 1'b1;
                    slv_addr = hold_addr;
                    mst_wait = 1'b1;
                end
                ST_WRITE: begin
                    slv_write = 1'b1;
                    slv_addr  = hold_addr;
                    slv_wdata = merged_q;
                    mst_wait  = 1'b1;
                end
                default: begin
                    slv_addr = hold_addr;
                    mst_wait = 1'b0;
                end
            endcase
        end
    end

    // R8: never a read and a write strobe together
    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(slv_read && slv_write));

    // R3: every slave access uses an aligned address
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_read || slv_write) |-> ((slv_addr & OFF_MASK) == '0));

    // R5: master held off throughout the read and write-back phases
    assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ || state == ST_WRITE) |-> mst_wait);

    // R6: empty-mask write is quiet and immediate
    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && mst_write && !mst_read && mst_lanes == '0)
            |-> (!slv_read && !slv_write && !mst_wait));

    // R7: a stalled read strobe is held with a stable address
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_read && slv_wait) |=> (slv_read && $stable(slv_addr)));

    // R9: reset silences the slave and holds off the master
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> (!slv_read && !slv_write && mst_wait));

endmodule

// File: tb/test_rmw_byte_bridge.sv
`timescale 1ns/1ps
module test_rmw_byte_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mst_addr = '0;
    logic        mst_read = 1'b0;
    logic        mst_write = 1'b0;
    logic [3:0]  mst_lanes = '0;
    logic [31:0] mst_wdata = '0;
    logic [31:0] mst_rdata;
    logic        mst_wait;
    logic [15:0] slv_addr;
    logic        slv_read;
    logic        slv_write;
    logic [31:0] slv_wdata;
    logic [31:0] slv_rdata;
    logic        slv_wait;

    int applied = 0;
    int miscompares = 0;
    int wait_n = 0;
    int wcnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int cyc = 0;
    logic [15:0] last_rd_addr = '0;
    logic [31:0] mem [16];
    logic [31:0] shadow [16];

    always #5 clk = ~clk;

    rmw_byte_bridge #(.ADDR_W(16), .DATA_W(32)) i_rmw_byte_bridge (
        .clk(clk), .rst_n(rst_n),
        .mst_addr(mst_addr), .mst_read(mst_read), .mst_write(mst_write),
        .mst_lanes(mst_lanes), .mst_wdata(mst_wdata),
        .mst_rdata(mst_rdata), .mst_wait(mst_wait),
        .slv_addr(slv_addr), .slv_read(slv_read), .slv_write(slv_write),
        .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_wait(slv_wait)
    );

    // Slave model: whole-word memory with a programmable stall per access
    assign slv_wait  = (slv_read || slv_write) && (wcnt < wait_n);
    assign slv_rdata = mem[slv_addr[5:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if ((slv_read || slv_write) && slv_wait) wcnt <= wcnt + 1;
        else                                     wcnt <= 0;
        if (slv_read && !slv_wait) begin
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= slv_addr;
        end
        if (slv_write && !slv_wait) begin
            wr_cnt <= wr_cnt + 1;
            mem[slv_addr[5:2]] <= slv_wdata;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 20000) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected < 20000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [3:0] ln,
                            input logic [31:0] d, output int hi);
        @(negedge clk);
        mst_addr = a; mst_lanes = ln; mst_wdata = d; mst_write = 1'b1;
        hi = 0;
        #2;
        while (mst_wait) begin
            hi++;
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        mst_write = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d, output int hi);
        @(negedge clk);
        mst_addr = a; mst_read = 1'b1;
        hi = 0;
        #2;
        while (mst_wait) begin
            hi++;
            @(negedge clk);
            #2;
        end
        d = mst_rdata;
        @(posedge clk);
        #1;
        mst_read = 1'b0;
    endtask

    // {address[15:0], lanes[3:0], data[31:0], stall[1:0]}
    localparam logic [53:0] VECS [10] = '{
        {16'h0000, 4'hF, 32'h1122_3344, 2'd0},
        {16'h0004, 4'h1, 32'h0000_00AB, 2'd0},
        {16'h23F3, 4'h8, 32'h4800_0000, 2'd0},
        {16'h0008, 4'h6, 32'h00CD_EF00, 2'd1},
        {16'h000C, 4'hF, 32'hDEAD_BEEF, 2'd2},
        {16'h0012, 4'h3, 32'h0000_BEEF, 2'd2},
        {16'h0014, 4'h0, 32'hFFFF_FFFF, 2'd0},
        {16'h0006, 4'hC, 32'h5566_0000, 2'd1},
        {16'h0018, 4'hE, 32'h7788_9900, 2'd3},
        {16'h0004, 4'hF, 32'h0102_0304, 2'd0}
    };

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 32'hC0DE_0000 | (32'(i) * 32'h0101);
            shadow[i] = 32'hC0DE_0000 | (32'(i) * 32'h0101);
        end
        // R9: reset gating, even with a full write presented
        mst_write = 1'b1; mst_lanes = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        check("R9 wait in reset", 32'(mst_wait), 32'd1);
        check("R9 read strobe in reset", 32'(slv_read), 32'd0);
        check("R9 write strobe in reset", 32'(slv_write), 32'd0);
        mst_write = 1'b0; mst_lanes = 4'h0;
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R9 idle wait after reset", 32'(mst_wait), 32'd0);

        for (int v = 0; v < 10; v++) begin
            logic [15:0] a;
            logic [3:0]  ln;
            logic [31:0] d;
            logic [31:0] rd;
            logic [31:0] expw;
            int hi, st, exp_hi, exp_rd, exp_wr, r0, w0;
            string kind;
            {a, ln, d} = VECS[v][53:2];
            st = int'(VECS[v][1:0]);
            wait_n = st;
            expw = shadow[a[5:2]];
            for (int b = 0; b < 4; b++)
                if (ln[b]) expw[8*b +: 8] = d[8*b +: 8];
            if (ln == 4'hF)      begin kind = "R1 full";    exp_hi = st;       exp_rd = 0; exp_wr = 1; end
            else if (ln != 4'h0) begin kind = "R5 partial"; exp_hi = 3 + 2*st; exp_rd = 1; exp_wr = 1; end
            else                 begin kind = "R6 empty";   exp_hi = 0;        exp_rd = 0; exp_wr = 0; end
            r0 = rd_cnt; w0 = wr_cnt;
            do_write(a, ln, d, hi);
            @(negedge clk);
            shadow[a[5:2]] = expw;
            check($sformatf("%s R7 held cycles v%0d", kind, v), 32'(hi), 32'(exp_hi));
            check($sformatf("%s R8 slave reads v%0d", kind, v), 32'(rd_cnt - r0), 32'(exp_rd));
            check($sformatf("%s R8 slave writes v%0d", kind, v), 32'(wr_cnt - w0), 32'(exp_wr));
            check($sformatf("R4 stored word v%0d", v), mem[a[5:2]], expw);
            if (exp_rd == 1)
                check($sformatf("R3 aligned read addr v%0d", v), 32'(last_rd_addr), 32'(a & 16'hFFFC));
            wait_n = 0;
            do_read(a, rd, hi);
            check($sformatf("R2 read back v%0d", v), rd, expw);
        end

        // R2 / R7: stalled pass-through read
        begin
            logic [31:0] rd;
            int hi;
            wait_n = 2;
            do_read(16'h0008, rd, hi);
            check("R2 stalled read data", rd, shadow[2]);
            check("R7 stalled read held cycles", 32'(hi), 32'd2);
            wait_n = 0;
        end

        // R3: the 9203 byte write read the word at 9200 (checked in loop);
        // confirm neighbours of that word kept their lanes
        check("R3 R4 neighbour lanes of 9203", mem[12] & 32'h00FF_FFFF, (32'hC0DE_0000 | 32'h0C0C) & 32'h00FF_FFFF);

        $display("  == %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule